// File: doc/BRIEF.md
# Variable-Length Chain Exit Selector

A linear chain of processing elements scores one query against a stream of reference symbols, with one query symbol held in each element starting from the first. A query shorter than the chain therefore fills only the leading elements, and the results it produces are already complete at an intermediate point in the chain. This block lets such a job take its results from the nearest exit point rather than from the end of the chain. Its latency then tracks the length of the segment it uses, not the full array.

The chain has a fixed set of exit points, called taps, at ascending depths. When a job starts, the selector is given the query length. It picks the shallowest tap whose depth is not below that length and holds that choice until the job finishes. While the job runs, the selected tap's valid and data are passed to the result collector. Valids from the other taps are masked. The block watches the reference stream entering the chain. When the last reference symbol enters, it counts the depth of the selected tap and raises a one-cycle completion flag in the cycle that symbol's result leaves the tap. A query longer than the deepest tap is refused with a one-cycle error flag and produces no results.

Top module: `vlx_exit_selector`

## Requirements
- R1: Tap depths are parameters in ascending order. Tap index 0 is the shallowest and sits in the lowest field of the depth vector. An accepted job uses the lowest-index tap whose depth is greater than or equal to its query length. A length of 0 selects tap 0.
- R2: The tap choice is fixed when the job is accepted and stays the same until the job's completion cycle.
- R3: While a job is active (`busy` high), `res_vld` equals the selected tap's valid bit and `res_data` equals that tap's data field. Tap k's data sits in bits k*DW and up of `tap_data`. When no job is active, `res_vld` is 0, whatever the taps present.
- R4: A job's reference stream ends at a cycle with `ref_vld` and `ref_last` both high. `job_done` is high for exactly one cycle, D cycles later, where D is the depth of the selected tap. `busy` remains high through that cycle and is low in the cycle after, unless a new job is accepted in the completion cycle.
- R5: `ref_vld` and `ref_last` have no effect while no job is active. A second end-of-stream marker after the first one of a job does not move the completion cycle.
- R6: If a start request carries a query length above the deepest tap, `job_err` is high for exactly the next cycle and no job begins: `busy` and `res_vld` remain low.
- R7: `job_start` is ignored while a job is active, except in the job's completion cycle, where it is accepted. The new job then becomes active in the next cycle, or is refused per R6.
- R8: While reset is held and until the first start request, `busy`, `res_vld`, `job_done` and `job_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| job_start | input | 1 | Start request for a new job |
| job_qlen | input | LW | Query length of the requested job |
| ref_vld | input | 1 | A reference symbol enters the first element this cycle |
| ref_last | input | 1 | The entering reference symbol is the job's last |
| tap_vld | input | NUM_TAPS | Valid bit of each tap's result stream |
| tap_data | input | NUM_TAPS*DW | Result data of each tap, tap k in bits k*DW and up |
| busy | output | 1 | A job is active |
| res_vld | output | 1 | Forwarded valid of the selected tap |
| res_data | output | DW | Forwarded data of the selected tap |
| job_done | output | 1 | One-cycle completion flag |
| job_err | output | 1 | One-cycle flag: query too long for the chain |

## Verification
The completion cycle of one job and the start request of the next can fall in the same cycle. The bench does this on purpose by raising `job_start` in the exact cycle its own count predicts for `job_done`. In that cycle it checks that the old tap is still forwarded. In the following cycle it checks that the new tap, or the error flag for an oversized query, has taken over. The bench also injects a start request and a repeated end-of-stream marker in the middle of each drain. It then confirms that neither changes the forwarded tap or the predicted completion cycle.

// File: rtl/vlx_pkg.sv
package vlx_pkg;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_RUN   = 2'd1,
    XS_DRAIN = 2'd2
  } xs_state_e;

endpackage

// File: rtl/vlx_exit_pick.sv
module vlx_exit_pick #(
  parameter int unsigned NUM_TAPS = 3,
  parameter int unsigned PW       = 8,
  parameter logic [NUM_TAPS*PW-1:0] TAP_POS = {8'd131, 8'd87, 8'd43},
  parameter int unsigned LW       = 8,
  localparam int unsigned IW      = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1
) (
  input  logic [LW-1:0] qlen,
  output logic [IW-1:0] idx,
  output logic [PW-1:0] depth,
  output logic          too_long
);

  logic found;

  // Priority scan from the shallowest tap upward.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    depth = TAP_POS[(NUM_TAPS-1)*PW +: PW];
    for (int k = 0; k < NUM_TAPS; k++) begin
      if (!found && (32'(qlen) <= 32'(TAP_POS[k*PW +: PW]))) begin
        found = 1'b1;
        idx   = IW'(k);
        depth = TAP_POS[k*PW +: PW];
      end
    end
    too_long = !found;
  end

  // Independent check: every tap below the chosen one is too short (R1).
  logic shallower_short;
  always_comb begin
    shallower_short = 1'b1;
    for (int k = 0; k < NUM_TAPS; k++) begin
      if ((IW'(k) < idx) && (32'(TAP_POS[k*PW +: PW]) >= 32'(qlen)))
        shallower_short = 1'b0;
    end
  end

  always_comb begin
    assert_pick_minimal_R1: assert (too_long || shallower_short);
    assert_pick_fits_R1:    assert (too_long || (32'(depth) >= 32'(qlen)));
  end

endmodule

// File: rtl/vlx_drain_timer.sv
module vlx_drain_timer #(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] load_val,
  output logic          at_one,
  output logic          running
);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign at_one  = (cnt_q == PW'(1));
  assign running = (cnt_q != '0);

  assert_load_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));

  assert_count_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - PW'(1)));

endmodule

// File: rtl/vlx_stream_mux.sv
module vlx_stream_mux #(
  parameter int unsigned NUM_TAPS = 3,
  parameter int unsigned DW       = 16,
  localparam int unsigned IW      = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1
) (
  input  logic [NUM_TAPS-1:0]    tap_vld,
  input  logic [NUM_TAPS*DW-1:0] tap_data,
  input  logic [IW-1:0]          sel,
  input  logic                   gate,
  output logic                   out_vld,
  output logic [DW-1:0]          out_data
);

  logic [DW-1:0] lane [NUM_TAPS];

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_lane
    assign lane[g] = tap_data[g*DW +: DW];
  end

  always_comb begin
    out_vld  = 1'b0;
    out_data = lane[0];
    for (int k = 0; k < NUM_TAPS; k++) begin
      if (sel == IW'(k)) begin
        out_vld  = gate && tap_vld[k];
        out_data = lane[k];
      end
    end
  end

endmodule

// File: rtl/vlx_exit_selector.sv
module vlx_exit_selector #(
  parameter int unsigned NUM_TAPS = 3,
  parameter int unsigned PW       = 8,
  parameter logic [NUM_TAPS*PW-1:0] TAP_POS = {8'd131, 8'd87, 8'd43},
  parameter int unsigned LW       = 8,
  parameter int unsigned DW       = 16,
  localparam int unsigned IW      = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   job_start,
  input  logic [LW-1:0]          job_qlen,
  input  logic                   ref_vld,
  input  logic                   ref_last,
  input  logic [NUM_TAPS-1:0]    tap_vld,
  input  logic [NUM_TAPS*DW-1:0] tap_data,
  output logic                   busy,
  output logic                   res_vld,
  output logic [DW-1:0]          res_data,
  output logic                   job_done,
  output logic                   job_err
);

  import vlx_pkg::*;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // Tap choice for the requested length.
  logic [IW-1:0] pick_idx;
  logic [PW-1:0] pick_depth;
  logic          pick_too_long;

  vlx_exit_pick #(
    .NUM_TAPS (NUM_TAPS),
    .PW       (PW),
    .TAP_POS  (TAP_POS),
    .LW       (LW)
  ) u_pick (
    .qlen     (job_qlen),
    .idx      (pick_idx),
    .depth    (pick_depth),
    .too_long (pick_too_long)
  );

  // Control state.
  xs_state_e     state_q, state_d;
  logic [IW-1:0] sel_q, sel_d;
  logic [PW-1:0] depth_q, depth_d;
  logic          err_q, err_d;
  logic          job_en;

  logic          at_one;
  logic          timer_run;
  logic          done_now;
  logic          accept;
  logic          last_in;

  assign done_now = (state_q == XS_DRAIN) && at_one;
  assign accept   = job_start && ((state_q == XS_IDLE) || done_now);
  assign last_in  = (state_q == XS_RUN) && ref_vld && ref_last;
  assign job_en   = accept;

  always_comb begin
    state_d = state_q;
    sel_d   = sel_q;
    depth_d = depth_q;
    err_d   = 1'b0;
    unique case (state_q)
      XS_IDLE:  state_d = XS_IDLE;
      XS_RUN:   if (last_in)  state_d = XS_DRAIN;
      XS_DRAIN: if (done_now) state_d = XS_IDLE;
      default:  state_d = XS_IDLE;
    endcase
    if (accept) begin
      if (pick_too_long) begin
        err_d = 1'b1;
      end else begin
        state_d = XS_RUN;
        sel_d   = pick_idx;
        depth_d = pick_depth;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= XS_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= '0;
      depth_q <= '0;
    end else if (job_en) begin
      sel_q   <= sel_d;
      depth_q <= depth_d;
    end
  end

  // Counts the selected depth after the last reference symbol enters.
  vlx_drain_timer #(
    .PW (PW)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_ni),
    .load     (last_in),
    .load_val (depth_q),
    .at_one   (at_one),
    .running  (timer_run)
  );

  assign busy = (state_q != XS_IDLE);

  vlx_stream_mux #(
    .NUM_TAPS (NUM_TAPS),
    .DW       (DW)
  ) u_mux (
    .tap_vld  (tap_vld),
    .tap_data (tap_data),
    .sel      (sel_q),
    .gate     (busy),
    .out_vld  (res_vld),
    .out_data (res_data)
  );

  assign job_done = done_now;
  assign job_err  = err_q;

  // Assertions
  assert_err_no_job_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    err_q |-> (state_q == XS_IDLE));

  assert_sel_held_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(state_q) != XS_IDLE && !$past(accept)) |-> $stable(sel_q));

  assert_drain_counts_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == XS_DRAIN) |-> timer_run);

  assert_done_ends_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (done_now && !accept) |=> (state_q == XS_IDLE));

  assert_busy_ignores_start_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == XS_RUN && job_start) |=> $stable(depth_q));

endmodule

// File: tb/sim_vlx_exit_selector.sv
module sim_vlx_exit_selector;

  localparam int NT = 3;
  localparam int PW = 4;
  localparam int LW = 4;
  localparam int DW = 8;
  localparam int MAXQ = 9;

  logic clk = 1'b0;
  logic rst_n;
  logic job_start, ref_vld, ref_last;
  logic [LW-1:0] job_qlen;
  logic [NT-1:0] tap_vld;
  logic [NT*DW-1:0] tap_data;
  logic busy, res_vld, job_done, job_err;
  logic [DW-1:0] res_data;
  logic [7:0] cyc;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  initial cyc = 8'd0;
  always @(posedge clk) cyc <= cyc + 8'd1;

  // Tap k data: upper nibble k+1, lower nibble cycle count; one tap dark per cycle.
  assign tap_vld = 3'b111 & ~(3'b001 << (cyc % 3));
  for (genvar g = 0; g < NT; g++) begin : g_tap
    assign tap_data[g*DW +: DW] = {4'(g + 1), cyc[3:0]};
  end

  vlx_exit_selector #(
    .NUM_TAPS (NT), .PW (PW), .TAP_POS ({4'd9, 4'd6, 4'd3}), .LW (LW), .DW (DW)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .job_start (job_start), .job_qlen (job_qlen),
    .ref_vld (ref_vld), .ref_last (ref_last), .tap_vld (tap_vld), .tap_data (tap_data),
    .busy (busy), .res_vld (res_vld), .res_data (res_data),
    .job_done (job_done), .job_err (job_err)
  );

  function automatic int exp_tap(int q);
    if (q <= 3) return 0;
    if (q <= 6) return 1;
    if (q <= 9) return 2;
    return 3;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic chk_stream(int e, string req);
    chk(res_vld == tap_vld[e], req, int'(res_vld), int'(tap_vld[e]));
    if (res_vld)
      chk(int'(res_data[7:4]) == e + 1, req, int'(res_data[7:4]), e + 1);
  endtask

  task automatic start_job(int q);
    job_start = 1'b1;
    job_qlen  = LW'(q);
    @(negedge clk);
    job_start = 1'b0;
    #1;
    if (q > MAXQ) begin
      chk(job_err == 1'b1, "R6 err pulse", int'(job_err), 1);
      chk(busy == 1'b0, "R6 no job", int'(busy), 0);
      chk(res_vld == 1'b0, "R6 no result", int'(res_vld), 0);
      @(negedge clk); #1;
      chk(job_err == 1'b0, "R6 single cycle", int'(job_err), 0);
    end else begin
      chk(busy == 1'b1, "R1 accepted", int'(busy), 1);
      chk_stream(exp_tap(q), "R1 tap");
    end
  endtask

  task automatic feed_drain(int e, int r, bit poke, bit chain, int q2);
    int d = 3 * (e + 1);
    for (int i = 0; i < r; i++) begin
      ref_vld  = 1'b1;
      ref_last = (i == r - 1);
      #1;
      chk_stream(e, "R3 run stream");
      chk(job_done == 1'b0, "R4 early done", int'(job_done), 0);
      @(negedge clk);
    end
    ref_vld = 1'b0; ref_last = 1'b0;
    for (int k = 1; k <= d; k++) begin
      if (poke && k == 1) begin job_start = 1'b1; job_qlen = '0; end
      if (poke && k == 2) begin ref_vld = 1'b1; ref_last = 1'b1; end
      if (chain && k == d) begin job_start = 1'b1; job_qlen = LW'(q2); end
      #1;
      chk(job_done == (k == d), "R4 done timing", int'(job_done), int'(k == d));
      chk(busy == 1'b1, "R4 busy drain", int'(busy), 1);
      chk_stream(e, poke ? "R7 R5 R2 held tap" : "R2 held tap");
      @(negedge clk);
      job_start = 1'b0; ref_vld = 1'b0; ref_last = 1'b0;
    end
    #1;
    if (!chain) begin
      chk(busy == 1'b0, "R4 idle after", int'(busy), 0);
      chk(res_vld == 1'b0, "R3 gated idle", int'(res_vld), 0);
      chk(job_done == 1'b0, "R4 one cycle", int'(job_done), 0);
    end else if (q2 > MAXQ) begin
      chk(job_err == 1'b1, "R7 R6 chained err", int'(job_err), 1);
      chk(busy == 1'b0, "R7 R6 chained idle", int'(busy), 0);
      @(negedge clk); #1;
    end else begin
      chk(busy == 1'b1, "R7 chained accept", int'(busy), 1);
      chk_stream(exp_tap(q2), "R7 chained tap");
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; job_start = 1'b0; job_qlen = '0; ref_vld = 1'b0; ref_last = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(busy == 1'b0 && res_vld == 1'b0, "R8 reset outputs", int'(busy), 0);
    chk(job_done == 1'b0 && job_err == 1'b0, "R8 reset flags", int'(job_done), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(busy == 1'b0 && res_vld == 1'b0, "R8 after release", int'(res_vld), 0);

    // Reference strobes with no job active.
    ref_vld = 1'b1; ref_last = 1'b1;
    @(negedge clk);
    ref_vld = 1'b0; ref_last = 1'b0;
    for (int i = 0; i < 12; i++) begin
      #1;
      chk(busy == 1'b0 && job_done == 1'b0, "R5 idle refs ignored", int'(job_done), 0);
      @(negedge clk);
    end

    // Sweep every query length.
    for (int q = 0; q < 16; q++) begin
      start_job(q);
      if (q <= MAXQ) feed_drain(exp_tap(q), 1 + q % 3, bit'(q % 2), 1'b0, 0);
      @(negedge clk);
    end

    // Back-to-back jobs: start lands in the completion cycle.
    start_job(2);
    feed_drain(0, 2, 1'b0, 1'b1, 8);
    feed_drain(2, 1, 1'b0, 1'b1, 5);
    feed_drain(1, 3, 1'b1, 1'b1, 12);
    start_job(7);
    feed_drain(2, 2, 1'b0, 1'b1, 0);
    feed_drain(0, 1, 1'b0, 1'b0, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule